// File: doc/BRIEF.md
# Error Status and Mask Register Block

This block gathers error events from a converter datapath and presents them to a control processor as a small register file. Three converters each raise a one-cycle overflow pulse when an over-range occurs. A clock-ratio checker drives a level that stays high for as long as the master-clock to frame-rate ratio is invalid. The block records the overflow pulses in sticky bits. Reading the status register returns the recorded bits and then clears them. The clock-error bit is not stored: it follows the live level.

An active-high mask register selects which sources can reach the status register. A mask bit of 1 lets its source through. A mask bit of 0 forces the matching status bit to 0. The same register file also holds a per-channel polarity-invert enable for six input channels. These enables are driven out to the datapath. A summary flag is high whenever any status bit reads 1.

The control bus framing is outside this block. Register access arrives as a decoded address together with separate read and write strobes. Read data is combinational from the address. A read of the status register takes effect on the clock edge that ends the read cycle.

Top module: `err_status_regs`

## Requirements
- R1: After reset the mask register, the invert register and all sticky bits are 0. The status register reads 0x00, `irq` is 0 and `inv_en` is 0.
- R2: An overflow pulse on `ovfl_evt[i]` (i = 0, 1, 2) whose mask bit is 1 sets status bit i from the following cycle. The bit stays set until the status register is read.
- R3: A read of the status register (address 0x19) returns its current value in that cycle. From the next cycle every sticky bit is 0.
- R4: An unmasked overflow pulse in the same cycle as a status read is not lost. The read returns the prior value, and the bit reads 1 on the next read.
- R5: Status bit 3 equals `clk_err_lvl` while mask bit 3 is 1, in the same cycle. It is never latched: it drops as soon as the level drops.
- R6: A status bit whose mask bit is 0 always reads 0. Overflow pulses that arrive while their mask bit is 0 are not recorded.
- R7: Clearing a mask bit from 1 to 0 discards its stored sticky bit. Setting the mask bit again does not make the old event reappear.
- R8: The mask register at address 0x1A is read/write in bits 3..0, using the same bit positions as the status register. Bits 7..4 read 0 and ignore writes.
- R9: The invert register at address 0x17 holds enables for channels 1..6 in bits 0..5. It drives `inv_en`, which changes on the edge that ends the write. Bits 7..6 read 0.
- R10: A write to the status address changes nothing. Reads of any address other than 0x17, 0x19 and 0x1A return 0x00.
- R11: `irq` is 1 exactly when the status register value is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ovfl_evt | input | 3 | Per-converter overflow event pulses |
| clk_err_lvl | input | 1 | Live invalid clock-ratio condition |
| rd_en | input | 1 | Read strobe for the addressed register |
| wr_en | input | 1 | Write strobe for the addressed register |
| addr | input | 8 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` (combinational) |
| irq | output | 1 | Summary: any status bit set |
| inv_en | output | 6 | Polarity-invert enables, channels 1..6 |

## Verification
The assertions assume that `addr` and the strobes are steady for the whole access cycle. They also assume that reads and writes to the same address never coincide, and that overflow events are single-cycle pulses sampled on the clock. The stimulus changes every input one time unit after a rising edge and holds it until the next one. It issues at most one access per cycle. It brings the clock-error level up and down on whole-cycle boundaries only, so the live path and the sticky path can be told apart in the same read.

// File: rtl/err_status_pkg.sv
// Package: shared register offsets for the error status block.
// Assumes an 8-bit register address space; offsets are fixed by the register map.
package err_status_pkg;
    localparam logic [7:0] ADDR_INV  = 8'h17;
    localparam logic [7:0] ADDR_STAT = 8'h19;
    localparam logic [7:0] ADDR_MASK = 8'h1A;
endpackage

// File: rtl/err_sticky_bank.sv
// Module: one sticky flag per overflow source.
// A flag sets on an unmasked event, clears on a status read (an event in the
// same cycle wins) and is held at 0 while its mask bit is 0.
// Assumes events are single-cycle pulses synchronous to clk.
module err_sticky_bank #(
    parameter int N_SRC = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] evt,
    input  logic [N_SRC-1:0] mask,
    input  logic             clr,
    output logic [N_SRC-1:0] flags
);
    for (genvar i = 0; i < N_SRC; i++) begin : g_bit
        // Capture, clear-on-read and mask gating for one source.
        always_ff @(posedge clk) begin
            if (!rst_n)
                flags[i] <= 1'b0;
            else if (!mask[i])
                flags[i] <= 1'b0;
            else
                flags[i] <= (flags[i] && !clr) || evt[i];
        end
    end
endmodule

// File: rtl/err_ctrl_regs.sv
// Module: writable control registers (source mask and channel invert).
// Only implemented bits are stored; reserved bits of wdata are dropped.
// Assumes one write per cycle, qualified by wr_en.
module err_ctrl_regs #(
    parameter int MASK_W = 4,
    parameter int N_INV  = 6,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [MASK_W-1:0] mask_q,
    output logic [N_INV-1:0]  inv_q
);
    import err_status_pkg::*;

    localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(ADDR_MASK);
    localparam logic [ADDR_W-1:0] A_INV  = ADDR_W'(ADDR_INV);

    // Mask register update.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask_q <= '0;
        else if (wr_en && addr == A_MASK)
            mask_q <= wdata[MASK_W-1:0];
    end

    // Channel-invert register update.
    always_ff @(posedge clk) begin
        if (!rst_n)
            inv_q <= '0;
        else if (wr_en && addr == A_INV)
            inv_q <= wdata[N_INV-1:0];
    end
endmodule

// File: rtl/err_read_mux.sv
// Module: address decode for register reads.
// Zero-extends each register to the bus width; unmapped addresses return 0.
module err_read_mux #(
    parameter int STAT_W = 4,
    parameter int N_INV  = 6,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [STAT_W-1:0] status,
    input  logic [STAT_W-1:0] mask,
    input  logic [N_INV-1:0]  inv,
    output logic [DATA_W-1:0] rdata
);
    import err_status_pkg::*;

    // Select the addressed register.
    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(ADDR_STAT))
            rdata = DATA_W'(status);
        else if (addr == ADDR_W'(ADDR_MASK))
            rdata = DATA_W'(mask);
        else if (addr == ADDR_W'(ADDR_INV))
            rdata = DATA_W'(inv);
    end
endmodule

// File: rtl/err_status_regs.sv
// Module: top of the error status block.
// Combines the sticky overflow flags with the live clock-error level, applies
// the active-high mask and clears the flags when the status register is read.
// Assumes rd_en and wr_en are single-cycle strobes with a stable addr.
module err_status_regs #(
    parameter int N_OVF  = 3,
    parameter int N_INV  = 6,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_OVF-1:0]  ovfl_evt,
    input  logic              clk_err_lvl,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq,
    output logic [N_INV-1:0]  inv_en
);
    import err_status_pkg::*;

    localparam int STAT_W = N_OVF + 1;

    logic [STAT_W-1:0] mask_q;
    logic [N_OVF-1:0]  sticky_q;
    logic [STAT_W-1:0] status;
    logic              rd_clr;

    // The status read clears the sticky flags on the closing edge.
    assign rd_clr = rd_en && (addr == ADDR_W'(ADDR_STAT));

    err_ctrl_regs #(
        .MASK_W(STAT_W), .N_INV(N_INV), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .mask_q(mask_q), .inv_q(inv_en)
    );

    err_sticky_bank #(.N_SRC(N_OVF)) u_sticky (
        .clk(clk), .rst_n(rst_n), .evt(ovfl_evt),
        .mask(mask_q[N_OVF-1:0]), .clr(rd_clr), .flags(sticky_q)
    );

    // Live clock-error bit above the sticky bits, all gated by the mask.
    assign status = {clk_err_lvl, sticky_q} & mask_q;
    assign irq    = |status;

    err_read_mux #(
        .STAT_W(STAT_W), .N_INV(N_INV), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
    ) u_rmux (
        .addr(addr), .status(status), .mask(mask_q), .inv(inv_en), .rdata(rdata)
    );
endmodule

// File: rtl/err_status_chk.sv
// Module: property checker for err_status_regs, attached by bind.
// Assumes the access and timing rules stated for the top module.
module err_status_chk #(
    parameter int N_OVF  = 3,
    parameter int N_INV  = 6,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [N_OVF-1:0]  ovfl_evt,
    input logic              clk_err_lvl,
    input logic              rd_en,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic [DATA_W-1:0] rdata,
    input logic              irq,
    input logic [N_INV-1:0]  inv_en,
    input logic [N_OVF:0]    mask,
    input logic [N_OVF-1:0]  sticky
);
    import err_status_pkg::*;

    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(ADDR_STAT);
    localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(ADDR_MASK);
    localparam logic [ADDR_W-1:0] A_INV  = ADDR_W'(ADDR_INV);

    // R1
    reset_clears_inv_chk: assert property (@(posedge clk)
        !rst_n |=> inv_en == '0);

    // R4
    read_keeps_new_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == A_STAT) |=> sticky == $past(ovfl_evt & mask[N_OVF-1:0]));

    // R6
    masked_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr == A_STAT |-> (rdata[N_OVF:0] & ~mask) == '0);

    // R5
    clk_err_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr == A_STAT |-> rdata[N_OVF] == (clk_err_lvl && mask[N_OVF]));

    // R8
    mask_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr == A_MASK |-> rdata[DATA_W-1:N_OVF+1] == '0);

    // R9
    inv_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_INV) |=> inv_en == $past(wdata[N_INV-1:0]));

    // R9
    inv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && addr == A_INV) |=> $stable(inv_en));

    // R10
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr != A_STAT && addr != A_MASK && addr != A_INV) |-> rdata == '0);

    // R11
    irq_matches_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr == A_STAT |-> irq == (rdata != '0));
endmodule

bind err_status_regs err_status_chk #(
    .N_OVF(N_OVF), .N_INV(N_INV), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .ovfl_evt(ovfl_evt), .clk_err_lvl(clk_err_lvl),
    .rd_en(rd_en), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .irq(irq), .inv_en(inv_en), .mask(mask_q), .sticky(sticky_q)
);

// File: tb/err_status_regs_tb.sv
// Bench: table-driven walk of register accesses and events, then directed
// tests for the invert output and reset during operation.
module err_status_regs_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 30;
    localparam logic [1:0] OP_ID = 2'd0, OP_WR = 2'd1, OP_RD = 2'd2;

    typedef struct packed {
        logic [1:0] op;
        logic [7:0] addr;
        logic [7:0] wd;
        logic [2:0] ov;
        logic       ce;
        logic [7:0] exp;
        logic       eirq;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{OP_RD, 8'h19, 8'h00, 3'b000, 1'b0, 8'h00, 1'b0},
        '{OP_RD, 8'h1A, 8'h00, 3'b000, 1'b0, 8'h00, 1'b0},
        '{OP_ID, 8'h00, 8'h00, 3'b111, 1'b1, 8'h00, 1'b0},
        '{OP_WR, 8'h1A, 8'hF5, 3'b000, 1'b0, 8'h00, 1'b0},
        '{OP_RD, 8'h1A, 8'h00, 3'b000, 1'b0, 8'h05, 1'b0},
        '{OP_RD, 8'h19, 8'h00, 3'b000, 1'b0, 8'h00, 1'b0},
        '{OP_ID, 8'h00, 8'h00, 3'b010, 1'b0, 8'h00, 1'b0},
        '{OP_ID, 8'h00, 8'h00, 3'b001, 1'b0, 8'h00, 1'b0},
        '{OP_RD, 8'h19, 8'h00, 3'b000, 1'b0, 8'h01, 1'b1},
        '{OP_RD, 8'h19, 8'h00, 3'b000, 1'b0, 8'h00, 1'b0},
        '{OP_ID, 8'h00, 8'h00, 3'b100, 1'b0, 8'h00, 1'b0},
        '{OP_ID, 8'h00, 8'h00, 3'b000, 1'b0, 8'h00, 1'b1},
        '{OP_RD, 8'h19, 8'h00, 3'b100, 1'b0, 8'h04, 1'b1},
        '{OP_RD, 8'h19, 8'h00, 3'b000, 1'b0, 8'h04, 1'b1},
        '{OP_RD, 8'h19, 8'h00, 3'b000, 1'b0, 8'h00, 1'b0},
        '{OP_WR, 8'h1A, 8'h0F, 3'b000, 1'b0, 8'h05, 1'b0},
        '{OP_ID, 8'h00, 8'h00, 3'b000, 1'b1, 8'h00, 1'b1},
        '{OP_RD, 8'h19, 8'h00, 3'b000, 1'b1, 8'h08, 1'b1},
        '{OP_RD, 8'h19, 8'h00, 3'b000, 1'b0, 8'h00, 1'b0},
        '{OP_ID, 8'h00, 8'h00, 3'b010, 1'b0, 8'h00, 1'b0},
        '{OP_WR, 8'h1A, 8'h0D, 3'b000, 1'b0, 8'h0F, 1'b1},
        '{OP_WR, 8'h1A, 8'h0F, 3'b000, 1'b0, 8'h0D, 1'b0},
        '{OP_RD, 8'h19, 8'h00, 3'b000, 1'b0, 8'h00, 1'b0},
        '{OP_WR, 8'h17, 8'hFF, 3'b000, 1'b0, 8'h00, 1'b0},
        '{OP_RD, 8'h17, 8'h00, 3'b000, 1'b0, 8'h3F, 1'b0},
        '{OP_WR, 8'h19, 8'hFF, 3'b000, 1'b0, 8'h00, 1'b0},
        '{OP_RD, 8'h19, 8'h00, 3'b000, 1'b0, 8'h00, 1'b0},
        '{OP_RD, 8'h1A, 8'h00, 3'b000, 1'b0, 8'h0F, 1'b0},
        '{OP_RD, 8'h18, 8'h00, 3'b000, 1'b0, 8'h00, 1'b0},
        '{OP_RD, 8'h1B, 8'h00, 3'b000, 1'b0, 8'h00, 1'b0}
    };

    // Requirement exercised by each vector, in table order.
    string vec_req [NV] = '{
        "R1", "R1", "R6", "R8", "R8", "R6", "R6", "R2", "R2", "R3",
        "R2", "R11", "R4", "R4", "R3", "R8", "R5", "R5", "R5", "R2",
        "R11", "R7", "R7", "R9", "R9", "R10", "R10", "R10", "R10", "R10"
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] ovfl_evt = '0;
    logic       clk_err_lvl = 1'b0;
    logic       rd_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       irq;
    logic [5:0] inv_en;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    err_status_regs u_dut (
        .clk(clk), .rst_n(rst_n), .ovfl_evt(ovfl_evt), .clk_err_lvl(clk_err_lvl),
        .rd_en(rd_en), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .irq(irq), .inv_en(inv_en)
    );

    task automatic check(input string req, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Drive one cycle of stimulus just after a rising edge.
    task automatic drive(input logic [1:0] op, input logic [7:0] a,
                         input logic [7:0] wd, input logic [2:0] ov, input logic ce);
        @(posedge clk);
        #1;
        rd_en = (op == OP_RD);
        wr_en = (op == OP_WR);
        addr = a;
        wdata = wd;
        ovfl_evt = ov;
        clk_err_lvl = ce;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check("R1", "inv_en after reset", {2'b00, inv_en}, 8'h00);
        check("R1", "irq after reset", {7'd0, irq}, 8'h00);

        for (int i = 0; i < NV; i++) begin
            drive(VECS[i].op, VECS[i].addr, VECS[i].wd, VECS[i].ov, VECS[i].ce);
            check(vec_req[i], $sformatf("vector %0d rdata", i), rdata, VECS[i].exp);
            check(vec_req[i], $sformatf("vector %0d irq", i), {7'd0, irq}, {7'd0, VECS[i].eirq});
        end

        // R9: invert enables reach the output port after the write edge.
        check("R9", "inv_en after full write", {2'b00, inv_en}, 8'h3F);
        drive(OP_WR, 8'h17, 8'hD5, 3'b000, 1'b0);
        drive(OP_ID, 8'h00, 8'h00, 3'b000, 1'b0);
        check("R9", "inv_en pattern", {2'b00, inv_en}, 8'h15);

        // R4: clock error live during a read that coincides with an event.
        drive(OP_ID, 8'h00, 8'h00, 3'b001, 1'b0);
        drive(OP_RD, 8'h19, 8'h00, 3'b010, 1'b1);
        check("R4", "read with event and clock error", rdata, 8'h09);
        drive(OP_RD, 8'h19, 8'h00, 3'b000, 1'b0);
        check("R4", "event from read cycle kept", rdata, 8'h02);

        // R1: reset during operation returns everything to zero.
        drive(OP_ID, 8'h00, 8'h00, 3'b111, 1'b0);
        @(posedge clk);
        #1 rst_n = 1'b0;
        ovfl_evt = '0;
        @(posedge clk);
        #1 rst_n = 1'b1;
        addr = 8'h1A;
        @(negedge clk);
        check("R1", "mask after reset", rdata, 8'h00);
        check("R1", "inv_en after reset", {2'b00, inv_en}, 8'h00);
        check("R1", "irq after reset", {7'd0, irq}, 8'h00);
        drive(OP_WR, 8'h1A, 8'h0F, 3'b000, 1'b0);
        drive(OP_RD, 8'h19, 8'h00, 3'b000, 1'b0);
        check("R1", "no sticky survives reset", rdata, 8'h00);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule